// File: doc/BRIEF.md
# Serial byte transmitter with clear-to-send gating

This block turns bytes written by a processor-style port into asynchronous serial frames on a single output line that rests high. A frame is a low start bit, eight data bits with the least significant bit first, and one or two high stop bits. Every bit lasts a fixed number of clock cycles set by a parameter, which the integrator derives from clock rate over baud rate or gives directly as a count. Bytes are held either in a single holding register (queue depth 0) or in a first-in first-out queue whose depth is a power of two.

An optional clear-to-send input, active high or active low, decides whether a new frame may begin. It is looked at only when a frame is about to start, so a frame that is under way always runs to its last stop bit. A busy output is meant for polling. Without a queue it means "a byte is held or on the wire", so software waits for it to fall before writing. With a queue it means "the queue is full". Writes are not guarded: a write into a full queue is dropped, and a write into the holding register while busy has an undefined result.

The sequencer has four states: WAIT_IDLE (line high), START_BIT, DATA_BITS and STOP_BITS. Transitions: LAUNCH (WAIT_IDLE to START_BIT, when a byte is available and sending is permitted, taking the byte), FIRST_DATA (START_BIT to DATA_BITS at the end of the bit), LAST_DATA (DATA_BITS to STOP_BITS at the end of data bit 7) and FRAME_DONE (STOP_BITS to WAIT_IDLE at the end of the last stop bit).

Top module: `uart_cts_tx`

## Requirements
- R1: After reset the output line is high and busy is low.
- R2: A frame starts on the clock edge after a byte becomes available while sending is permitted. Its start bit drives the line low for CYCLES_PER_BIT cycles.
- R3: The eight data bits follow the start bit, least significant first, each one held for CYCLES_PER_BIT cycles.
- R4: STOP_BITS (1 or 2) high stop bits of CYCLES_PER_BIT cycles each end the frame. The line then stays high for at least one cycle before any next start bit.
- R5: Bytes are sent in the order they were accepted. A byte that is already waiting starts its frame exactly one idle cycle after the previous frame ends.
- R6: With FIFO_DEPTH > 0, busy is high exactly when the queue holds FIFO_DEPTH bytes.
- R7: With FIFO_DEPTH = 0, busy is high while a byte is held and not yet taken, or a frame is in progress. This includes a byte held back by clear-to-send.
- R8: A write arriving while the queue is full is dropped. It never reaches the line, even if a byte leaves the queue in that same cycle.
- R9: CTS_MODE selects the gating. 0 means always permitted, 1 means permitted while cts_in is 1, and 2 means permitted while cts_in is 0. A new frame starts only while sending is permitted.
- R10: Clear-to-send is evaluated only for the start of a frame. Withdrawing it during a frame does not shorten or alter that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_data | input | 8 | Byte to send, taken when wr_stb is high |
| cts_in | input | 1 | Clear-to-send, polarity set by CTS_MODE |
| tx_line | output | 1 | Serial output, high when idle |
| busy | output | 1 | Polling status, meaning set by FIFO_DEPTH (R6, R7) |

## Verification
The bench builds two instances with a bit period of 4 cycles, so whole frames fit in a few dozen cycles. The first has a four-deep queue, two stop bits and active-low clear-to-send. With it, the queue can be filled while sending is blocked, the overflow write dropped, the full-queue busy boundary measured, and back-to-back frames observed. The second has no queue, one stop bit and active-high clear-to-send. It exposes the "held or sending" meaning of busy, and shows a held byte kept back while permission is withdrawn.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [1:0] {
        TX_WAIT_IDLE = 2'd0,
        TX_START_BIT = 2'd1,
        TX_DATA_BITS = 2'd2,
        TX_STOP_BITS = 2'd3
    } tx_state_e;

    localparam int BYTE_BITS = 8;

    typedef logic [BYTE_BITS-1:0] tx_byte_t;

    // Gate selection: 0 = always permitted, 1 = cts high permits, 2 = cts low permits
    function automatic logic cts_permits(input logic cts, input int mode);
        logic ok;
        unique case (mode)
            1:       ok = cts;
            2:       ok = ~cts;
            default: ok = 1'b1;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer #(
    parameter int CYCLES_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic bit_end
);
    localparam int CNT_W = (CYCLES_PER_BIT > 1) ? $clog2(CYCLES_PER_BIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES_PER_BIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hold || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign bit_end = !hold && (cnt_q == LAST);

    // R2: the period counter never passes its terminal value
    p_count_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R2: holding the timer restarts the bit period from zero
    p_hold_restarts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> cnt_q == '0);

endmodule

// File: rtl/uart_tx_store.sv
module uart_tx_store
    import uart_tx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  tx_byte_t push_data,
    input  logic     pop,
    output logic     avail,
    output tx_byte_t head,
    output logic     full
);

    generate
        if (DEPTH == 0) begin : g_hold
            logic     valid_q;
            tx_byte_t data_q;

            // Unguarded: a write always lands, even over an unsent byte
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    valid_q <= 1'b0;
                    data_q  <= '0;
                end else if (push) begin
                    valid_q <= 1'b1;
                    data_q  <= push_data;
                end else if (pop) begin
                    valid_q <= 1'b0;
                end
            end

            assign avail = valid_q;
            assign head  = data_q;
            assign full  = valid_q;

            // R5: the sequencer takes a byte only when one is held
            p_pop_only_when_avail_r5: assert property (@(posedge clk) disable iff (!rst_n)
                pop |-> valid_q);
        end else begin : g_fifo
            localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
            localparam int CNT_W = $clog2(DEPTH + 1);
            localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
            localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

            tx_byte_t         mem_q [DEPTH];
            logic [PTR_W-1:0] wr_ptr_q;
            logic [PTR_W-1:0] rd_ptr_q;
            logic [CNT_W-1:0] count_q;
            logic             accept;

            function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
                return (p == PTR_LAST) ? '0 : p + 1'b1;
            endfunction

            // Fullness is judged before any same-cycle pop
            assign accept = push && (count_q != CNT_FULL);

            always_ff @(posedge clk) begin
                if (accept) begin
                    mem_q[wr_ptr_q] <= push_data;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    wr_ptr_q <= '0;
                    rd_ptr_q <= '0;
                    count_q  <= '0;
                end else begin
                    if (accept) begin
                        wr_ptr_q <= ptr_next(wr_ptr_q);
                    end
                    if (pop) begin
                        rd_ptr_q <= ptr_next(rd_ptr_q);
                    end
                    unique case ({accept, pop})
                        2'b10:   count_q <= count_q + 1'b1;
                        2'b01:   count_q <= count_q - 1'b1;
                        default: count_q <= count_q;
                    endcase
                end
            end

            assign avail = (count_q != '0);
            assign head  = mem_q[rd_ptr_q];
            assign full  = (count_q == CNT_FULL);

            // R5: the sequencer never takes from an empty queue
            p_pop_only_when_avail_r5: assert property (@(posedge clk) disable iff (!rst_n)
                pop |-> count_q != '0);

            // R6: occupancy stays within the configured depth
            p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
                count_q <= CNT_FULL);

            // R8: a write into a full queue leaves the write pointer where it was
            p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (full && push) |=> $stable(wr_ptr_q));
        end
    endgenerate

endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
    import uart_tx_pkg::*;
#(
    parameter int STOP_BITS = 1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     avail,
    input  tx_byte_t head,
    input  logic     cts_ok,
    input  logic     bit_end,
    output logic     pop,
    output logic     idle,
    output logic     timer_hold,
    output logic     tx
);
    localparam int IDX_W = $clog2(BYTE_BITS);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BYTE_BITS - 1);
    localparam logic STOP_LAST = 1'(STOP_BITS - 1);

    tx_state_e        state_q;
    tx_state_e        state_d;
    tx_byte_t         shift_q;
    logic [IDX_W-1:0] bit_idx_q;
    logic             stop_idx_q;
    logic             launch;
    logic             stop_done;

    assign launch    = (state_q == TX_WAIT_IDLE) && avail && cts_ok;
    assign stop_done = (stop_idx_q == STOP_LAST);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_WAIT_IDLE: if (launch)                             state_d = TX_START_BIT;
            TX_START_BIT: if (bit_end)                            state_d = TX_DATA_BITS;
            TX_DATA_BITS: if (bit_end && bit_idx_q == IDX_LAST)   state_d = TX_STOP_BITS;
            TX_STOP_BITS: if (bit_end && stop_done)               state_d = TX_WAIT_IDLE;
            default:                                              state_d = TX_WAIT_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_WAIT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Shift register and bit counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q    <= '0;
            bit_idx_q  <= '0;
            stop_idx_q <= 1'b0;
        end else begin
            unique case (state_q)
                TX_WAIT_IDLE: begin
                    bit_idx_q  <= '0;
                    stop_idx_q <= 1'b0;
                    if (launch) begin
                        shift_q <= head;
                    end
                end
                TX_DATA_BITS: begin
                    if (bit_end) begin
                        shift_q   <= shift_q >> 1;
                        bit_idx_q <= bit_idx_q + 1'b1;
                    end
                end
                TX_STOP_BITS: begin
                    if (bit_end && !stop_done) begin
                        stop_idx_q <= 1'b1;
                    end
                end
                default: begin
                    shift_q <= shift_q;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        pop        = launch;
        idle       = (state_q == TX_WAIT_IDLE);
        timer_hold = (state_q == TX_WAIT_IDLE);
        unique case (state_q)
            TX_START_BIT: tx = 1'b0;
            TX_DATA_BITS: tx = shift_q[0];
            default:      tx = 1'b1;
        endcase
    end

    // R9: no frame begins while sending is not permitted
    p_wait_for_cts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_WAIT_IDLE && !cts_ok) |=> state_q == TX_WAIT_IDLE);

    // R10: before the stop phase a running frame cannot return to idle
    p_frame_completes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != TX_WAIT_IDLE && state_q != TX_STOP_BITS) |=> state_q != TX_WAIT_IDLE);

    // R3: data phase keeps going until all eight bits have been sent
    p_data_continues_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_DATA_BITS && bit_end && bit_idx_q != IDX_LAST) |=> state_q == TX_DATA_BITS);

    // R4: a finished frame leaves at least one idle cycle
    p_idle_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_STOP_BITS && bit_end && stop_done) |=> state_q == TX_WAIT_IDLE);

endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx
    import uart_tx_pkg::*;
#(
    parameter int CYCLES_PER_BIT = 16,
    parameter int STOP_BITS      = 1,
    parameter int FIFO_DEPTH     = 4,
    parameter int CTS_MODE       = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  logic [7:0] wr_data,
    input  logic       cts_in,
    output logic       tx_line,
    output logic       busy
);
    logic     cts_ok;
    logic     st_avail;
    logic     st_full;
    tx_byte_t st_head;
    logic     ser_pop;
    logic     ser_idle;
    logic     tmr_hold;
    logic     tmr_end;

    assign cts_ok = cts_permits(cts_in, CTS_MODE);

    uart_tx_store #(
        .DEPTH (FIFO_DEPTH)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_stb),
        .push_data (wr_data),
        .pop       (ser_pop),
        .avail     (st_avail),
        .head      (st_head),
        .full      (st_full)
    );

    uart_tx_bit_timer #(
        .CYCLES_PER_BIT (CYCLES_PER_BIT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (tmr_hold),
        .bit_end (tmr_end)
    );

    uart_tx_serializer #(
        .STOP_BITS (STOP_BITS)
    ) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .avail      (st_avail),
        .head       (st_head),
        .cts_ok     (cts_ok),
        .bit_end    (tmr_end),
        .pop        (ser_pop),
        .idle       (ser_idle),
        .timer_hold (tmr_hold),
        .tx         (tx_line)
    );

    generate
        if (FIFO_DEPTH == 0) begin : g_busy_hold
            assign busy = st_full || !ser_idle;
        end else begin : g_busy_fifo
            assign busy = st_full;
        end
    endgenerate

endmodule

// File: tb/uart_cts_tx_model.sv
module uart_cts_tx_model #(
    parameter int CPB      = 4,
    parameter int STOP     = 1,
    parameter int DEPTH    = 4,
    parameter int CTS_MODE = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] data,
    input  logic       cts,
    input  logic       dut_line,
    input  logic       dut_busy,
    output int         checks_o,
    output int         errors_o
);
    localparam int TOTAL = (9 + STOP) * CPB;

    int         q[$];
    logic [7:0] cur;
    bit         active;
    int         t;
    int         n_chk = 0;
    int         n_err = 0;
    logic [7:0] got[$];
    bit         rx_on;
    int         rc;
    logic [7:0] rbyte;

    assign checks_o = n_chk;
    assign errors_o = n_err;

    function automatic bit permitted(input logic c);
        if (CTS_MODE == 1) return c;
        if (CTS_MODE == 2) return !c;
        return 1'b1;
    endfunction

    function automatic bit exp_line();
        int idx;
        if (!active) return 1'b1;
        idx = t / CPB;
        if (idx == 0) return 1'b0;
        if (idx <= 8) return cur[idx-1];
        return 1'b1;
    endfunction

    // Behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            active = 0;
            t = 0;
            cur = 8'h00;
        end else begin
            bit pre_full;
            pre_full = (DEPTH > 0) && (q.size() == DEPTH);
            if (active) begin
                if (t == TOTAL - 1) active = 0;
                else t++;
            end else if (q.size() > 0 && permitted(cts)) begin
                cur = 8'(q.pop_front());
                active = 1;
                t = 0;
            end
            if (wr) begin
                if (DEPTH > 0) begin
                    if (!pre_full) q.push_back(int'(data));
                end else begin
                    if (q.size() == 0) q.push_back(int'(data));
                    else q[0] = int'(data);
                end
            end
        end
    end

    // Compare outputs and decode frames away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit eb;
            bit el;
            string tag;
            el = exp_line();
            if (!active) tag = "R4";
            else if (t / CPB == 0) tag = "R2";
            else if (t / CPB <= 8) tag = "R3";
            else tag = "R4";
            n_chk++;
            if (dut_line !== el) begin
                n_err++;
                $display("FAIL %s line at %0t: got %0b expected %0b", tag, $time, dut_line, el);
            end
            if (DEPTH > 0) begin
                eb = (q.size() == DEPTH);
                tag = "R6";
            end else begin
                eb = (q.size() > 0) || active;
                tag = "R7";
            end
            n_chk++;
            if (dut_busy !== eb) begin
                n_err++;
                $display("FAIL %s busy at %0t: got %0b expected %0b", tag, $time, dut_busy, eb);
            end
            if (!rx_on && dut_line == 1'b0) begin
                rx_on = 1;
                rc = 0;
            end else if (rx_on) begin
                rc++;
                if (rc % CPB == CPB / 2) begin
                    if (rc / CPB >= 1 && rc / CPB <= 8) rbyte[rc/CPB-1] = dut_line;
                    if (rc / CPB == 9) begin
                        got.push_back(rbyte);
                        rx_on = 0;
                    end
                end
            end
        end else begin
            rx_on = 0;
            rc = 0;
        end
    end

endmodule

// File: tb/uart_cts_tx_test.sv
module uart_cts_tx_test;
    localparam int CPB = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr0, wr1, cts0, cts1;
    logic [7:0] d0, d1;
    logic       tx0, busy0, tx1, busy1;
    int         checks = 0;
    int         errors = 0;
    int         m0_chk, m0_err, m1_chk, m1_err;
    bit         timed_out = 0;

    always #5 clk = ~clk;

    uart_cts_tx #(.CYCLES_PER_BIT(CPB), .STOP_BITS(2), .FIFO_DEPTH(4), .CTS_MODE(2)) uut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr0), .wr_data(d0), .cts_in(cts0),
        .tx_line(tx0), .busy(busy0));

    uart_cts_tx #(.CYCLES_PER_BIT(CPB), .STOP_BITS(1), .FIFO_DEPTH(0), .CTS_MODE(1)) uut_nf (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr1), .wr_data(d1), .cts_in(cts1),
        .tx_line(tx1), .busy(busy1));

    uart_cts_tx_model #(.CPB(CPB), .STOP(2), .DEPTH(4), .CTS_MODE(2)) m0 (
        .clk(clk), .rst_n(rst_n), .wr(wr0), .data(d0), .cts(cts0),
        .dut_line(tx0), .dut_busy(busy0), .checks_o(m0_chk), .errors_o(m0_err));

    uart_cts_tx_model #(.CPB(CPB), .STOP(1), .DEPTH(0), .CTS_MODE(1)) m1 (
        .clk(clk), .rst_n(rst_n), .wr(wr1), .data(d1), .cts(cts1),
        .dut_line(tx1), .dut_busy(busy1), .checks_o(m1_chk), .errors_o(m1_err));

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic write0(input logic [7:0] b);
        @(negedge clk);
        wr0 = 1'b1;
        d0  = b;
        @(negedge clk);
        wr0 = 1'b0;
    endtask

    task automatic write1(input logic [7:0] b);
        @(negedge clk);
        wr1 = 1'b1;
        d1  = b;
        @(negedge clk);
        wr1 = 1'b0;
    endtask

    task automatic hold_high(input int n, input bit which, input string tag);
        bit stayed = 1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if ((which ? tx1 : tx0) !== 1'b1) stayed = 0;
        end
        check(stayed, tag, "line held high while blocked", stayed, 1);
    endtask

    task automatic run_tests();
        // R1: reset state
        check(tx0 === 1'b1 && tx1 === 1'b1, "R1", "line after reset", {tx0, tx1}, 2'b11);
        check(busy0 === 1'b0 && busy1 === 1'b0, "R1", "busy after reset", {busy0, busy1}, 2'b00);

        // R6, R8, R9: fill the queue while sending is blocked
        write0(8'hA1);
        write0(8'hB2);
        write0(8'hC3);
        check(busy0 === 1'b0, "R6", "busy with three queued", busy0, 0);
        write0(8'hD4);
        check(busy0 === 1'b1, "R6", "busy with queue full", busy0, 1);
        write0(8'hE5);
        hold_high(20, 1'b0, "R9");
        check(busy0 === 1'b1, "R6", "busy still full", busy0, 1);
        cts0 = 1'b0;
        repeat (200) @(negedge clk);
        check(m0.got.size() == 4, "R8", "frames after overflow write", m0.got.size(), 4);
        if (m0.got.size() == 4) begin
            check(m0.got[0] == 8'hA1 && m0.got[1] == 8'hB2, "R5", "order first pair",
                  {m0.got[0], m0.got[1]}, 16'hA1B2);
            check(m0.got[2] == 8'hC3 && m0.got[3] == 8'hD4, "R5", "order second pair",
                  {m0.got[2], m0.got[3]}, 16'hC3D4);
        end
        check(busy0 === 1'b0, "R6", "busy after draining", busy0, 0);

        // R10: withdrawing permission mid-frame
        write0(8'h55);
        repeat (2) @(negedge clk);
        check(tx0 === 1'b0, "R2", "start bit under way", tx0, 0);
        cts0 = 1'b1;
        repeat (60) @(negedge clk);
        check(m0.got.size() == 5 && m0.got[4] == 8'h55, "R10", "frame completed after withdraw",
              (m0.got.size() == 5) ? m0.got[4] : 0, 8'h55);
        write0(8'h66);
        hold_high(60, 1'b0, "R9");
        cts0 = 1'b0;
        repeat (60) @(negedge clk);
        check(m0.got.size() == 6 && m0.got[5] == 8'h66, "R9", "held byte sent after release",
              (m0.got.size() == 6) ? m0.got[5] : 0, 8'h66);

        // R7: holding register variant
        write1(8'h3C);
        check(busy1 === 1'b1, "R7", "busy once byte held", busy1, 1);
        repeat (50) @(negedge clk);
        check(busy1 === 1'b0, "R7", "busy after frame", busy1, 0);
        check(m1.got.size() == 1 && m1.got[0] == 8'h3C, "R3", "byte decoded",
              (m1.got.size() == 1) ? m1.got[0] : 0, 8'h3C);
        cts1 = 1'b0;
        write1(8'h0F);
        hold_high(80, 1'b1, "R9");
        check(busy1 === 1'b1, "R7", "busy while held back", busy1, 1);
        cts1 = 1'b1;
        repeat (50) @(negedge clk);
        check(m1.got.size() == 2 && m1.got[1] == 8'h0F, "R9", "active-high release",
              (m1.got.size() == 2) ? m1.got[1] : 0, 8'h0F);
        check(busy1 === 1'b0, "R7", "busy after release", busy1, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        wr0 = 1'b0; wr1 = 1'b0;
        d0 = 8'h00; d1 = 8'h00;
        cts0 = 1'b1;
        cts1 = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        fork
            run_tests();
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
        end
        $display("CHECKS %0d ERRORS %0d", checks + m0_chk + m1_chk, errors + m0_err + m1_err);
        $finish;
    end

endmodule